// File: doc/BRIEF.md
# Disk Rotational Position Timer

This block tracks where a head-per-track disk is in its revolution. A prescaler divides the clock by a programmable word period. Each completed period moves a word-position counter forward by one. The counter wraps after 2048 positions per revolution. Several signals are derived from that position: an index (photocell) status that is true near the start of each revolution, a match flag for a search-and-skip test against the requested disk address, and a transfer-start pulse that arrives once the disk has turned to the requested word.

A controller issues a one-cycle start request together with the low address bits of the target word. The block holds the target and waits for the rotational latency, which is the distance from the current position to the target modulo 2048, in word periods. It then emits one transfer-start pulse. While the photocell interrupt enable is held high, the block also raises a one-cycle interrupt pulse each time the position wraps to zero. Dropping the enable before the wrap cancels that event.

The start scheduler is a two-state machine. In state ST_IDLE a start request latches the target and moves to ST_WAIT. In state ST_WAIT the block stays until the position equals the latched target, then pulses the transfer start and returns to ST_IDLE.

Top module: `disk_rotor`

## Requirements
- R1: After reset the position is 0, the scheduler is in ST_IDLE (busy low), and the transfer-start and photocell interrupt outputs are low.
- R2: With a word period of P clocks, the position advances by exactly one every P clocks, and from 2047 it wraps to 0. After k clocks from reset at a constant P, the position is floor(k/P) mod 2048.
- R3: A word period of 0 is treated as 1, so the position advances on every clock.
- R4: The index output is high exactly while the position is below 6.
- R5: The match output is high exactly when the 11-bit target input equals the position.
- R6: A start request in ST_IDLE latches the target and sets busy on the next cycle. The transfer-start pulse is high for one cycle, in the first cycle in ST_WAIT where the position equals the latched target. Busy falls on the cycle after that. The wait therefore spans (target − position) mod 2048 word periods.
- R7: A start request while busy is ignored. The transfer still fires at the target that was first latched.
- R8: When the photocell enable is high at the wrap from 2047 to 0, the interrupt output pulses for exactly one cycle. That cycle is the first one at position 0, so the index output is also high in it.
- R9: When the photocell enable is low at the wrap, no interrupt pulse occurs. Dropping the enable cancels the pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 16 | Word period in clocks (0 acts as 1) |
| target_i | input | 11 | Low disk-address bits: the word to reach |
| start_i | input | 1 | One-cycle transfer start request |
| pc_ie_i | input | 1 | Photocell interrupt enable |
| pos_o | output | 11 | Current word position |
| index_o | output | 1 | Photocell status, position below 6 |
| match_o | output | 1 | Target equals position |
| busy_o | output | 1 | Transfer pending (ST_WAIT) |
| xfer_start_o | output | 1 | One-cycle first-word transfer pulse |
| pc_irq_o | output | 1 | One-cycle photocell interrupt pulse |

## Verification
Some properties are checked on every cycle. The position only holds or steps by one. The index output rises only at position 0 and falls only at position 6. An interrupt pulse occurs only at position 0, and only after the enable was high on the previous cycle. Busy rises only after a start request, and each transfer pulse is followed by busy clearing. Other behaviour needs the bench's scenarios: the exact latency in clocks against a prescaler phase, the divide ratio including the zero period, and that a second start leaves the latched target unchanged. The bench also shows that exactly one interrupt arrives per revolution, and none once the enable is withdrawn.

// File: rtl/rot_pkg.sv
package rot_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seek_state_t;
endpackage

// File: rtl/rot_prescaler.sv
module rot_prescaler #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                tick_o
);
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] last;

    // zero period behaves as one clock per word
    always_comb begin
        last   = (period_i == '0) ? '0 : period_i - 1'b1;
        tick_o = (cnt_q >= last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rot_position.sv
module rot_position #(
    parameter int POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [POS_W-1:0] pos_o,
    output logic             wrap_o
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    assign wrap_o = tick_i && (pos_o == POS_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n)      pos_o <= '0;
        else if (tick_i) pos_o <= pos_o + 1'b1;
    end
endmodule

// File: rtl/rot_seek.sv
module rot_seek
    import rot_pkg::*;
#(
    parameter int POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [POS_W-1:0] target_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             busy_o,
    output logic             xfer_o
);
    seek_state_t      state_q, state_d;
    logic [POS_W-1:0] tgt_q;
    logic             arrived;

    assign arrived = (pos_i == tgt_q);

    // state register and target latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) tgt_q <= target_i;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_WAIT;
            ST_WAIT: if (arrived) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o = 1'b0;
        xfer_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                busy_o = 1'b1;
                xfer_o = arrived;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rot_photocell.sv
module rot_photocell (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic ie_i,
    output logic irq_o
);
    // event is raised on entry to position 0; a low enable drops it
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= wrap_i && ie_i;
    end
endmodule

// File: rtl/disk_rotor.sv
module disk_rotor #(
    parameter int PERIOD_W     = 16,
    parameter int POS_W        = 11,
    parameter int INDEX_WINDOW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [POS_W-1:0]    target_i,
    input  logic                start_i,
    input  logic                pc_ie_i,
    output logic [POS_W-1:0]    pos_o,
    output logic                index_o,
    output logic                match_o,
    output logic                busy_o,
    output logic                xfer_start_o,
    output logic                pc_irq_o
);
    localparam logic [POS_W-1:0] WIN = POS_W'(INDEX_WINDOW);

    logic tick;
    logic wrap;

    rot_prescaler #(.PERIOD_W(PERIOD_W)) u_prs (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .tick_o(tick)
    );

    rot_position #(.POS_W(POS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .pos_o(pos_o), .wrap_o(wrap)
    );

    rot_seek #(.POS_W(POS_W)) u_seek (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
        .pos_i(pos_o), .busy_o(busy_o), .xfer_o(xfer_start_o)
    );

    rot_photocell u_pc (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .ie_i(pc_ie_i), .irq_o(pc_irq_o)
    );

    assign index_o = (pos_o < WIN);
    assign match_o = (target_i == pos_o);
endmodule

// File: rtl/disk_rotor_sva.sv
module disk_rotor_sva #(
    parameter int POS_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             pc_ie_i,
    input logic [POS_W-1:0] pos_o,
    input logic             index_o,
    input logic             busy_o,
    input logic             xfer_start_o,
    input logic             pc_irq_o
);
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (pos_o == '0) && !busy_o && !xfer_start_o && !pc_irq_o);

    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o != $past(pos_o)) |-> (pos_o == POS_W'($past(pos_o) + 1'b1)));

    a_r4_index_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(index_o) |-> (pos_o == '0));

    a_r4_index_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(index_o) |-> (pos_o == POS_W'(6)));

    a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    a_r6_pulse_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |=> !busy_o && !xfer_start_o);

    a_r8_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pc_irq_o |-> (pos_o == '0) && index_o);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pc_irq_o |-> $past(pc_ie_i));
endmodule

bind disk_rotor disk_rotor_sva #(.POS_W(POS_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_ie_i(pc_ie_i),
    .pos_o(pos_o), .index_o(index_o), .busy_o(busy_o),
    .xfer_start_o(xfer_start_o), .pc_irq_o(pc_irq_o)
);

// File: tb/test_disk_rotor.sv
module test_disk_rotor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period_i = 16'd1;
    logic [10:0] target_i = '0;
    logic        start_i = 1'b0;
    logic        pc_ie_i = 1'b0;
    logic [10:0] pos_o;
    logic        index_o, match_o, busy_o, xfer_start_o, pc_irq_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    disk_rotor i_disk_rotor (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .target_i(target_i),
        .start_i(start_i), .pc_ie_i(pc_ie_i), .pos_o(pos_o), .index_o(index_o),
        .match_o(match_o), .busy_o(busy_o), .xfer_start_o(xfer_start_o),
        .pc_irq_o(pc_irq_o)
    );

    // reference position model from the divide rule
    int m_cnt = 0;
    int m_pos = 0;
    always @(posedge clk) begin
        int eff;
        eff = (period_i == 0) ? 1 : int'(period_i);
        if (!rst_n) begin
            m_cnt <= 0; m_pos <= 0;
        end else if (m_cnt + 1 >= eff) begin
            m_cnt <= 0; m_pos <= (m_pos + 1) % 2048;
        end else begin
            m_cnt <= m_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // issue a start and measure clocks until the transfer pulse
    task automatic seek(input int tgt, input string req);
        int n, expc, cnt;
        @(negedge clk);
        target_i = 11'(tgt);
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        target_i = 11'(tgt + 5);
        check(busy_o || xfer_start_o, req, int'(busy_o), 1);
        n    = (tgt - m_pos + 2048) % 2048;
        expc = (n == 0) ? 0 : n * ((period_i == 0) ? 1 : int'(period_i)) - m_cnt;
        cnt  = 0;
        while (!xfer_start_o && cnt < 20000) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == expc, req, cnt, expc);
        check(int'(pos_o) == tgt, req, int'(pos_o), tgt);
        @(negedge clk);
        check(!busy_o && !xfer_start_o, req, int'(busy_o), 0);
    endtask

    typedef struct packed {
        logic [15:0] per;
        logic [10:0] tgt;
    } vec_t;
    localparam vec_t VECS [5] = '{
        '{per: 16'd1, tgt: 11'd40},
        '{per: 16'd3, tgt: 11'd2047},
        '{per: 16'd2, tgt: 11'd7},
        '{per: 16'd1, tgt: 11'd0},
        '{per: 16'd4, tgt: 11'd300}
    };

    initial begin
        #1600000;
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int errs;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pos_o == 0 && !busy_o && !xfer_start_o && !pc_irq_o && index_o,
              "R1", int'(pos_o), 0);
        rst_n = 1'b1;

        // R2 / R4 / R5 across a full wrap at period 1, then period 2
        target_i = 11'd9;
        errs = 0;
        for (int i = 0; i < 4200; i++) begin
            @(negedge clk);
            if (i == 2100) period_i = 16'd2;
            if (int'(pos_o) != m_pos) errs++;
        end
        check(errs == 0, "R2", errs, 0);
        errs = 0;
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            if (index_o != (pos_o < 6)) errs++;
        end
        check(errs == 0, "R4", errs, 0);
        errs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            target_i = pos_o + 11'(i % 2);
            #1;
            if (match_o != (i % 2 == 0)) errs++;
        end
        check(errs == 0, "R5", errs, 0);

        // R3 zero period
        period_i = 16'd0;
        @(negedge clk);
        errs = int'(pos_o);
        @(negedge clk);
        check(int'(pos_o) == (errs + 1) % 2048, "R3", int'(pos_o), (errs + 1) % 2048);

        // R6 latency table
        foreach (VECS[k]) begin
            @(negedge clk);
            period_i = VECS[k].per;
            repeat (5) @(negedge clk);
            seek(int'(VECS[k].tgt), "R6");
        end

        // R7 second start while waiting is ignored
        period_i = 16'd1;
        @(negedge clk);
        target_i = pos_o + 11'd100;
        errs = int'(pos_o) + 100;
        start_i = 1'b1;
        @(negedge clk);
        target_i = pos_o + 11'd10;
        @(negedge clk);
        start_i = 1'b0;
        while (!xfer_start_o) @(negedge clk);
        check(int'(pos_o) == errs % 2048, "R7", int'(pos_o), errs % 2048);

        // R8 one pulse per revolution, at position 0
        pc_ie_i = 1'b1;
        errs = 0;
        for (int i = 0; i < 2048; i++) begin
            @(negedge clk);
            if (pc_irq_o) begin
                errs++;
                check(pos_o == 0 && index_o, "R8", int'(pos_o), 0);
            end
        end
        check(errs == 1, "R8", errs, 1);

        // R9 enable dropped before the wrap cancels the event
        while (pos_o != 11'd2040) @(negedge clk);
        pc_ie_i = 1'b0;
        errs = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pc_irq_o) errs++;
        end
        check(errs == 0, "R9", errs, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule